// File: doc/BRIEF.md
# Sensor Timing Counter Synchronizer

This block holds the pixel (horizontal) and line (vertical) counters of an image-sensor timing core. It keeps them aligned with timing that comes from outside the core. It derives the core's line and frame strobes from those counters. Downstream waveform generators read the counters and strobes. They also watch an output-hold flag, which tells them to park their clock outputs at idle levels.

Two alignment schemes are available, and one configuration bit picks between them.

- **Master scheme.** A single synchronization pin resets everything. Its active level is programmable. While the pin is active, both counters stay at zero and the strobes stay low. When the pin returns to inactive, counting restarts from zero. A suspend option raises the hold flag for as long as the pin is active. With suspend off, the flag stays low.
- **Slave scheme.** The synchronization pin is ignored. Instead, an active frame-strobe edge arms the aligner. The next active line-strobe edge then zeroes both counters a fixed number of clocks later. The counters start running at that first alignment.

All three outside inputs go through a multi-flop synchronizer, and every latency below includes that synchronizer. The pixel counter wraps at a programmable last-pixel index. The line counter steps on each pixel wrap and wraps at a programmable last-line index.

Top module: `tcore_sync`

## Requirements
- R1: While `rst_n` is low, `pix_cnt` and `line_cnt` are 0 and `hd_out`, `vd_out`, `hold_out` and `run_out` are 0.
- R2: In master mode (`cfg_mode`=0), while `sync_in` is at its active level, `pix_cnt`=0, `line_cnt`=0, and `hd_out`=`vd_out`=0.
- R3: In master mode, suppose `sync_in` goes inactive between clock edges. After the n-th following rising edge, `pix_cnt` equals 0 for n below 3 and (n-3) mod (`cfg_line_last`+1) from n=3 on.
- R4: Once running and not held, `pix_cnt` counts 0..`cfg_line_last` and then wraps. `line_cnt` increments on each pixel wrap and wraps to 0 after `cfg_frame_last`.
- R5: `hd_out` is 1 exactly when the counters are running, not held by sync, and `pix_cnt`=0. `vd_out` is `hd_out` with the added condition `line_cnt`=0.
- R6: In master mode with `cfg_suspend`=1, `hold_out` is 1 after the 1st and 2nd edges following sync activation or release as the synchronized level dictates. It is 1 throughout the active period and 0 from the 3rd edge after release. With `cfg_suspend`=0, `hold_out` stays 0.
- R7: `cfg_sync_pol`=0 makes low the active `sync_in` level, so the rising edge releases. `cfg_sync_pol`=1 makes high active, so the falling edge releases.
- R8: In slave mode (`cfg_mode`=1), `sync_in` has no effect: counters keep counting and `hold_out` stays 0.
- R9: In slave mode, an active `vd_in` edge arms the aligner. Suppose the next active `hd_in` edge is applied between clock edges. Then, after the 17th following rising edge, `pix_cnt`=0 and `line_cnt`=0, and after the (17+m)-th edge `pix_cnt` = m mod (`cfg_line_last`+1).
- R10: An active `hd_in` edge with no prior unconsumed `vd_in` edge does not realign. Each `vd_in` edge arms exactly one alignment.
- R11: `cfg_strobe_pol`=0 makes falling edges of `vd_in`/`hd_in` active, and `cfg_strobe_pol`=1 makes rising edges active.
- R12: `run_out` is 1 from the first edge after reset in master mode. In slave mode it is 0, with counters frozen at 0, until the first alignment edge, where it becomes 1. It never falls outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External synchronization pin (master mode) |
| vd_in | input | 1 | External frame strobe (slave mode) |
| hd_in | input | 1 | External line strobe (slave mode) |
| cfg_mode | input | 1 | 0 master, 1 slave |
| cfg_sync_pol | input | 1 | Active level of `sync_in` |
| cfg_strobe_pol | input | 1 | 0 falling, 1 rising edges of strobes active |
| cfg_suspend | input | 1 | Enable output hold during sync |
| cfg_line_last | input | PIX_W | Last pixel index of a line |
| cfg_frame_last | input | LINE_W | Last line index of a frame |
| pix_cnt | output | PIX_W | Pixel counter |
| line_cnt | output | LINE_W | Line counter |
| vd_out | output | 1 | Internal frame strobe |
| hd_out | output | 1 | Internal line strobe |
| hold_out | output | 1 | Clock outputs must rest at idle levels |
| run_out | output | 1 | Timing operation started |

## Verification
The hardest situation to reach is the slave aligner's arming state. A line-strobe edge must be rejected when no frame edge preceded it. It must also be rejected when the frame edge was already consumed. The realignment has to land exactly seventeen clocks after the accepted edge.

The stimulus first issues lone line edges. It checks that the counters keep their free-running values, computed from elapsed cycles. It then pairs a frame edge with a line edge and samples the counters on both sides of the predicted landing cycle. Master release timing is swept over several line and frame lengths, with every cycle after release compared against modular arithmetic.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   localparam int unsigned EXT_SYNC = 0;
   localparam int unsigned EXT_VD   = 1;
   localparam int unsigned EXT_HD   = 2;
   localparam int unsigned EXT_N    = 3;

   typedef enum logic {
      MODE_MASTER = 1'b0,
      MODE_SLAVE  = 1'b1
   } tcs_mode_e;
endpackage

// File: rtl/tcs_input_sync.sv
module tcs_input_sync #(
   parameter int unsigned N      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] cur,
   output logic [N-1:0] prv
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tcs_input_sync: at least two stages required");
   end

   for (genvar g = 0; g < N; g++) begin : g_chain
      logic [STAGES:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-1:0], raw[g]};
      end
      assign cur[g] = chain_q[STAGES-1];
      assign prv[g] = chain_q[STAGES];
   end
endmodule

// File: rtl/tcs_slave_align.sv
module tcs_slave_align #(
   parameter int unsigned LATENCY = 17,
   parameter int unsigned STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic vd_edge,
   input  logic hd_edge,
   output logic fire
);
   // Edge detection already spends STAGES+1 edges of the total latency.
   localparam int unsigned LOAD  = LATENCY - STAGES - 1;
   localparam int unsigned DLY_W = (LOAD < 2) ? 1 : $clog2(LOAD + 1);

   if (LATENCY < STAGES + 2) begin : g_bad_latency
      $error("tcs_slave_align: latency shorter than synchronizer path");
   end

   logic             armed_q;
   logic [DLY_W-1:0] dly_q;
   logic             accept;

   assign accept = en & armed_q & hd_edge & (dly_q == '0);
   assign fire   = en & (dly_q == DLY_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         dly_q   <= '0;
      end else if (!en) begin
         armed_q <= 1'b0;
         dly_q   <= '0;
      end else begin
         if (accept)              dly_q <= DLY_W'(LOAD);
         else if (dly_q != '0)    dly_q <= dly_q - 1'b1;
         if (vd_edge)             armed_q <= 1'b1;
         else if (accept)         armed_q <= 1'b0;
      end
   end

   // R9: a pending alignment counts down one per clock
   a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (en && dly_q != '0) |=> (dly_q == $past(dly_q) - 1'b1));

   // R10: an unarmed line edge never starts an alignment
   a_r10_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !armed_q && dly_q == '0) |=> (dly_q == '0));
endmodule

// File: rtl/tcs_counters.sv
module tcs_counters #(
   parameter int unsigned PIX_W  = 12,
   parameter int unsigned LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              run,
   input  logic [PIX_W-1:0]  line_last,
   input  logic [LINE_W-1:0] frame_last,
   output logic [PIX_W-1:0]  pix,
   output logic [LINE_W-1:0] line
);
   logic pix_wrap;
   logic line_wrap;

   assign pix_wrap  = (pix == line_last);
   assign line_wrap = (line == frame_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix  <= '0;
         line <= '0;
      end else if (clear) begin
         pix  <= '0;
         line <= '0;
      end else if (run) begin
         if (pix_wrap) begin
            pix  <= '0;
            line <= line_wrap ? '0 : line + 1'b1;
         end else begin
            pix  <= pix + 1'b1;
         end
      end
   end

   // R4: pixel steps by one inside a line
   a_r4_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear && pix != line_last) |=> (pix == $past(pix) + 1'b1));

   // R4: pixel returns to zero at the line end
   a_r4_pix_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear && pix == line_last) |=> (pix == '0));

   // R4: line returns to zero at the frame end
   a_r4_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear && pix == line_last && line == frame_last) |=> (line == '0));
endmodule

// File: rtl/tcore_sync.sv
module tcore_sync
   import tcs_pkg::*;
#(
   parameter int unsigned PIX_W         = 12,
   parameter int unsigned LINE_W        = 11,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned ALIGN_LATENCY = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_in,
   input  logic              vd_in,
   input  logic              hd_in,
   input  logic              cfg_mode,
   input  logic              cfg_sync_pol,
   input  logic              cfg_strobe_pol,
   input  logic              cfg_suspend,
   input  logic [PIX_W-1:0]  cfg_line_last,
   input  logic [LINE_W-1:0] cfg_frame_last,
   output logic [PIX_W-1:0]  pix_cnt,
   output logic [LINE_W-1:0] line_cnt,
   output logic              vd_out,
   output logic              hd_out,
   output logic              hold_out,
   output logic              run_out
);
   if (PIX_W < 2 || LINE_W < 1) begin : g_bad_width
      $error("tcore_sync: counter widths too small");
   end

   logic [EXT_N-1:0] raw, cur, prv;
   tcs_mode_e        mode;
   logic             is_master;
   logic             act_now, act_old, zero_hold;
   logic             vd_now, vd_old, hd_now, hd_old;
   logic             vd_edge, hd_edge, fire;
   logic             hold_q, run_q;

   assign raw[EXT_SYNC] = sync_in;
   assign raw[EXT_VD]   = vd_in;
   assign raw[EXT_HD]   = hd_in;

   tcs_input_sync #(.N(EXT_N), .STAGES(SYNC_STAGES)) u_isync (
      .clk(clk), .rst_n(rst_n), .raw(raw), .cur(cur), .prv(prv));

   assign mode      = tcs_mode_e'(cfg_mode);
   assign is_master = (mode == MODE_MASTER);

   // Sync is active when its synchronized level equals the polarity bit.
   assign act_now   = ~(cur[EXT_SYNC] ^ cfg_sync_pol);
   assign act_old   = ~(prv[EXT_SYNC] ^ cfg_sync_pol);
   assign zero_hold = is_master & (act_now | act_old);

   // Strobe polarity inverts before the falling-edge detector.
   assign vd_now  = cur[EXT_VD] ^ cfg_strobe_pol;
   assign vd_old  = prv[EXT_VD] ^ cfg_strobe_pol;
   assign hd_now  = cur[EXT_HD] ^ cfg_strobe_pol;
   assign hd_old  = prv[EXT_HD] ^ cfg_strobe_pol;
   assign vd_edge = vd_old & ~vd_now;
   assign hd_edge = hd_old & ~hd_now;

   tcs_slave_align #(.LATENCY(ALIGN_LATENCY), .STAGES(SYNC_STAGES)) u_align (
      .clk(clk), .rst_n(rst_n), .en(~is_master),
      .vd_edge(vd_edge), .hd_edge(hd_edge), .fire(fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         run_q  <= 1'b0;
      end else begin
         hold_q <= is_master & cfg_suspend & act_now;
         run_q  <= run_q | is_master | fire;
      end
   end

   tcs_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(zero_hold | fire), .run(run_q),
      .line_last(cfg_line_last), .frame_last(cfg_frame_last),
      .pix(pix_cnt), .line(line_cnt));

   assign hd_out   = run_q & ~zero_hold & (pix_cnt == '0);
   assign vd_out   = hd_out & (line_cnt == '0);
   assign hold_out = hold_q;
   assign run_out  = run_q;

   // R2: while outputs are held the counters sit at zero
   a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hold_out |-> (pix_cnt == '0 && line_cnt == '0));

   // R9: an alignment lands both counters on zero
   a_r9_align_zero: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (pix_cnt == '0 && line_cnt == '0));

   // R12: once started, timing never stops
   a_r12_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(run_out));
endmodule

// File: tb/tcore_sync_bench.sv
`timescale 1ns/1ps
module tcore_sync_bench;
   localparam int unsigned PW = 12;
   localparam int unsigned LW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync_in = 1'b1, vd_in = 1'b1, hd_in = 1'b1;
   logic          cfg_mode = 1'b0, cfg_sync_pol = 1'b0, cfg_strobe_pol = 1'b0;
   logic          cfg_suspend = 1'b0;
   logic [PW-1:0] cfg_line_last = PW'(7);
   logic [LW-1:0] cfg_frame_last = LW'(3);
   logic [PW-1:0] pix_cnt;
   logic [LW-1:0] line_cnt;
   logic          vd_out, hd_out, hold_out, run_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tcore_sync u_tcore_sync (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .vd_in(vd_in), .hd_in(hd_in),
      .cfg_mode(cfg_mode), .cfg_sync_pol(cfg_sync_pol),
      .cfg_strobe_pol(cfg_strobe_pol), .cfg_suspend(cfg_suspend),
      .cfg_line_last(cfg_line_last), .cfg_frame_last(cfg_frame_last),
      .pix_cnt(pix_cnt), .line_cnt(line_cnt), .vd_out(vd_out), .hd_out(hd_out),
      .hold_out(hold_out), .run_out(run_out));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_reset(input logic mode, input logic spol, input logic stpol,
                           input logic susp, input int ll, input int fl);
      rst_n = 1'b0;
      cfg_mode = mode; cfg_sync_pol = spol; cfg_strobe_pol = stpol;
      cfg_suspend = susp;
      cfg_line_last = PW'(ll); cfg_frame_last = LW'(fl);
      sync_in = ~spol; vd_in = stpol ? 1'b0 : 1'b1; hd_in = stpol ? 1'b0 : 1'b1;
      step(3);
      chk("R1 pix in reset", pix_cnt, 0);
      chk("R1 line in reset", line_cnt, 0);
      chk("R1 strobes in reset", {hd_out, vd_out}, 0);
      chk("R1 hold/run in reset", {hold_out, run_out}, 0);
      rst_n = 1'b1;
      step(4);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // Master sweep over line and frame lengths, suspend on and off
      for (int li = 0; li < 3; li++) begin
         for (int fi = 0; fi < 2; fi++) begin
            int ll, fl, pe, le, he;
            logic susp;
            ll = (li == 2) ? 6 : 3 + li;
            fl = 1 + fi;
            susp = logic'(fi);
            do_reset(1'b0, 1'b0, 1'b0, susp, ll, fl);
            chk("R12 master run", run_out, 1);
            sync_in = 1'b0;
            step(6);
            chk("R2 pix held", pix_cnt, 0);
            chk("R2 line held", line_cnt, 0);
            chk("R2 strobes low", {hd_out, vd_out}, 0);
            chk("R6 hold during sync", hold_out, int'(susp));
            sync_in = 1'b1;
            for (int n = 1; n <= 40; n++) begin
               step(1);
               pe = (n < 3) ? 0 : (n - 3) % (ll + 1);
               le = (n < 3) ? 0 : ((n - 3) / (ll + 1)) % (fl + 1);
               he = (n >= 3 && pe == 0) ? 1 : 0;
               chk("R3 pix after release", pix_cnt, pe);
               chk("R4 line after release", line_cnt, le);
               chk("R5 hd_out", hd_out, he);
               chk("R5 vd_out", vd_out, (he == 1 && le == 0) ? 1 : 0);
               chk("R6 hold after release", hold_out, (susp && n < 3) ? 1 : 0);
            end
         end
      end

      // R7: active-high sync
      do_reset(1'b0, 1'b1, 1'b0, 1'b1, 100, 5);
      sync_in = 1'b1;
      step(6);
      chk("R7 pix held active-high", pix_cnt, 0);
      chk("R7 hold active-high", hold_out, 1);
      sync_in = 1'b0;
      step(10);
      chk("R7 pix after falling release", pix_cnt, 7);
      chk("R7 hold released", hold_out, 0);

      // Slave mode, falling strobes
      begin
         int p;
         do_reset(1'b1, 1'b0, 1'b0, 1'b1, 999, 5);
         chk("R12 slave not running", run_out, 0);
         hd_in = 1'b0;
         step(30);
         chk("R10 lone hd no run", run_out, 0);
         chk("R10 lone hd pix", pix_cnt, 0);
         hd_in = 1'b1;
         step(3);
         vd_in = 1'b0;
         step(3);
         vd_in = 1'b1;
         step(4);
         hd_in = 1'b0;
         step(16);
         chk("R12 run before landing", run_out, 0);
         step(1);
         chk("R12 run at landing", run_out, 1);
         chk("R9 pix at landing", pix_cnt, 0);
         chk("R9 line at landing", line_cnt, 0);
         step(5);
         chk("R9 pix after landing", pix_cnt, 5);
         // R8: sync pulse is ignored in slave mode
         p = int'(pix_cnt);
         sync_in = 1'b0;
         step(10);
         chk("R8 pix keeps counting", pix_cnt, p + 10);
         chk("R8 no hold in slave", hold_out, 0);
         sync_in = 1'b1;
         // R10: second hd edge without a new vd edge
         hd_in = 1'b1;
         step(3);
         p = int'(pix_cnt);
         hd_in = 1'b0;
         step(30);
         chk("R10 consumed arm", pix_cnt, p + 30);
         // Re-arm and realign
         vd_in = 1'b0;
         step(3);
         vd_in = 1'b1;
         step(3);
         hd_in = 1'b1;
         step(3);
         hd_in = 1'b0;
         step(25);
         chk("R9 realign pix", pix_cnt, 8);
         chk("R9 realign line", line_cnt, 0);
      end

      // R11: rising strobes active, with a counting sweep after landing
      do_reset(1'b1, 1'b0, 1'b1, 1'b0, 3, 3);
      vd_in = 1'b1;
      step(2);
      vd_in = 1'b0;
      step(3);
      hd_in = 1'b1;
      step(17);
      chk("R11 run on rising edges", run_out, 1);
      for (int m = 0; m <= 20; m++) begin
         int pe, le;
         if (m > 0) step(1);
         pe = m % 4;
         le = (m / 4) % 4;
         chk("R11 pix after rising align", pix_cnt, pe);
         chk("R4 line after rising align", line_cnt, le);
         chk("R5 slave hd_out", hd_out, (pe == 0) ? 1 : 0);
         chk("R5 slave vd_out", vd_out, (pe == 0 && le == 0) ? 1 : 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule